// File: doc/BRIEF.md
# SPI Slave Engine with Address-Compare Filter

This block is the receive and transmit engine of a serial peripheral slave. The external master supplies the serial clock, the active-low select and the data input. The engine samples them in the system clock domain after synchronising them. It shifts incoming bits into a byte, moves each completed byte into a receive buffer and raises an available flag and a one-cycle interrupt pulse. In the same transfer it shifts a parallel transmit byte out on the data output, which has its own output-enable for tristate.

An optional compare filter lets several slaves share one bus. When the filter is armed, the first byte of a transfer is received silently, with the output undriven, and is checked against a compare value. A match gives a one-cycle match pulse, which can wake the system, and opens the rest of the transfer to normal handling. A mismatch mutes the slave until select is released.

The control bits and the compare value come in as plain inputs from a register owned by the surrounding logic. A read strobe clears the available flag. A clear strobe clears the overrun flag.

Top module: `spi_cmp_slave`

## Requirements
- R1: Data input bits are sampled on rising serial-clock edges, most significant bit first. When the DW-th bit arrives, the byte appears on rx_data_o, rx_avail_o is set and rx_irq_o pulses high for exactly one system clock.
- R2: While the engine is active, spi_miso_o carries bit DW-1 of tx_byte_i from the moment select goes low, and advances one bit after each falling serial-clock edge. At the falling edge that follows a completed byte, a fresh tx_byte_i is loaded.
- R3: If a byte completes while rx_avail_o is still set, ovr_o is set and rx_data_o takes the new byte. ovr_o then stays set until a cycle with ovr_clr_i high.
- R4: A one-cycle rx_rd_i pulse clears rx_avail_o and leaves rx_data_o unchanged.
- R5: With cfg_cmp_en_i high when select goes low, the first byte raises no rx_irq_o, does not change rx_data_o, and spi_miso_oe_o stays low while it is received.
- R6: If that first byte equals cmp_value_i, match_o pulses high for exactly one system clock. The following bytes of the transfer are then received and transmitted as in R1 and R2.
- R7: If that first byte differs from cmp_value_i, no later byte of the same transfer raises rx_irq_o or changes the buffer, and spi_miso_oe_o stays low until select goes high.
- R8: With cfg_hiz_i high, spi_miso_oe_o stays low and reception is unaffected.
- R9: Releasing select in the middle of a byte discards the partial bits without raising any flag. The next transfer starts bit-aligned and compare state starts fresh.
- R10: With cfg_enable_i low, serial activity raises no flag, and the buffer and spi_miso_oe_o stay unchanged.
- R11: After reset, spi_miso_oe_o, rx_data_o, rx_avail_o, rx_irq_o, ovr_o and match_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck_i | input | 1 | Serial clock from the master (idles low) |
| spi_ss_n_i | input | 1 | Slave select, active low |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out (0 when not enabled) |
| spi_miso_oe_o | output | 1 | Output enable for the data-out pad |
| tx_byte_i | input | DW | Parallel byte to transmit |
| cfg_enable_i | input | 1 | Engine enable |
| cfg_cmp_en_i | input | 1 | Arms the compare filter for the next transfer |
| cfg_hiz_i | input | 1 | Holds data out tristated |
| cmp_value_i | input | DW | Value the first byte is compared with |
| rx_rd_i | input | 1 | Buffer read strobe, clears the available flag |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rx_data_o | output | DW | Receive buffer |
| rx_avail_o | output | 1 | Byte available flag |
| rx_irq_o | output | 1 | One-cycle pulse per byte delivered |
| ovr_o | output | 1 | Overrun flag |
| match_o | output | 1 | One-cycle compare match / wake pulse |

## Verification
The bench builds the engine with DW = 8 and two synchroniser stages, and holds each serial-clock half period for six system clocks. This leaves room for the synchroniser and edge-detect latency before each sample. With 8-bit bytes, random data can hit the compare value by chance as well as through the directed cases. Multi-byte transfers with random read skipping reach overrun and the transmit reload across byte boundaries. Short transfers aborted after a few bits reach the resynchronisation path.

// File: rtl/scs_pkg.sv
// Shared types for the SPI slave compare engine.
// Assumes nothing beyond a standard SystemVerilog package scope.
package scs_pkg;

    // Filter state of the current transfer.
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,   // select inactive or engine disabled
        FS_CMP  = 2'd1,   // waiting for the compare byte
        FS_PASS = 2'd2,   // normal slave traffic
        FS_MUTE = 2'd3    // compare failed, ignore until release
    } filt_state_t;

endpackage

// File: rtl/scs_sync.sv
// Multi-bit, multi-stage synchroniser for slow, independent control inputs.
// Assumes every bit is sampled independently and its reset value is given by RST_VAL.
module scs_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= d_i;
                end
            end else begin : g_next
                // Pass the value down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/scs_shifter.sv
// Bit engine: shifts receive bits on serial-clock rises, transmit bits on falls.
// Assumes act_i/start_i/rise_i/fall_i are single-clock qualified events in the system domain.
module scs_shifter #(
    parameter int DW = 8,
    localparam int CW = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_i,
    input  logic          start_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          mosi_i,
    input  logic [DW-1:0] tx_byte_i,
    output logic          byte_done_o,
    output logic [DW-1:0] rx_byte_o,
    output logic          miso_bit_o
);

    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [CW-1:0] cnt_q;
    logic [DW-1:0] rx_q;
    logic [DW-1:0] tx_q;

    // Receive shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !act_i) begin
            cnt_q <= '0;
            rx_q  <= '0;
        end else if (rise_i) begin
            rx_q  <= {rx_q[DW-2:0], mosi_i};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Transmit shift register: load on start and at byte boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (start_i) begin
            tx_q <= tx_byte_i;
        end else if (act_i && fall_i) begin
            if (cnt_q == '0) tx_q <= tx_byte_i;
            else             tx_q <= {tx_q[DW-2:0], 1'b0};
        end
    end

    assign byte_done_o = act_i && rise_i && (cnt_q == LAST);
    assign rx_byte_o   = {rx_q[DW-2:0], mosi_i};
    assign miso_bit_o  = tx_q[DW-1];

endmodule

// File: rtl/scs_filter.sv
// Compare filter: decides whether completed bytes are delivered and DO is driven.
// Assumes compare enable is sampled once, on the start event of a transfer.
module scs_filter
    import scs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_i,
    input  logic          start_i,
    input  logic          byte_done_i,
    input  logic [DW-1:0] rx_byte_i,
    input  logic          cmp_en_i,
    input  logic [DW-1:0] cmp_value_i,
    input  logic          hiz_i,
    output logic          deliver_o,
    output logic          match_o,
    output logic          oe_o,
    output logic          muted_o
);

    filt_state_t state_q;
    logic        match_q;

    // Transfer filter state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || !act_i) begin
            state_q <= FS_IDLE;
        end else if (start_i) begin
            state_q <= cmp_en_i ? FS_CMP : FS_PASS;
        end else if (byte_done_i && state_q == FS_CMP) begin
            state_q <= (rx_byte_i == cmp_value_i) ? FS_PASS : FS_MUTE;
        end
    end

    // One-clock match pulse on a successful compare.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= act_i && !start_i && byte_done_i &&
                               (state_q == FS_CMP) && (rx_byte_i == cmp_value_i);
    end

    assign deliver_o = byte_done_i && (state_q == FS_PASS);
    assign match_o   = match_q;
    assign oe_o      = (state_q == FS_PASS) && !hiz_i;
    assign muted_o   = (state_q == FS_MUTE);

endmodule

// File: rtl/scs_rxbuf.sv
// Receive buffer with available, interrupt and overrun flags.
// Assumes deliver_i is a single-clock strobe; a delivery wins over a same-cycle clear.
module scs_rxbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          deliver_i,
    input  logic [DW-1:0] byte_i,
    input  logic          rd_i,
    input  logic          ovr_clr_i,
    output logic [DW-1:0] data_o,
    output logic          avail_o,
    output logic          irq_o,
    output logic          ovr_o
);

    logic [DW-1:0] data_q;
    logic          avail_q;
    logic          irq_q;
    logic          ovr_q;

    // Buffer contents and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            avail_q <= 1'b0;
            irq_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            irq_q <= deliver_i;
            if (deliver_i) begin
                data_q  <= byte_i;
                avail_q <= 1'b1;
                if (avail_q) ovr_q <= 1'b1;
                else if (ovr_clr_i) ovr_q <= 1'b0;
            end else begin
                if (rd_i)      avail_q <= 1'b0;
                if (ovr_clr_i) ovr_q   <= 1'b0;
            end
        end
    end

    assign data_o  = data_q;
    assign avail_o = avail_q;
    assign irq_o   = irq_q;
    assign ovr_o   = ovr_q;

endmodule

// File: rtl/spi_cmp_slave.sv
// SPI slave engine with optional first-byte compare filter (top level).
// Assumes the serial clock idles low, is much slower than clk, and that
// control and compare inputs come from a register owned by the surroundings.
module spi_cmp_slave #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck_i,
    input  logic          spi_ss_n_i,
    input  logic          spi_mosi_i,
    output logic          spi_miso_o,
    output logic          spi_miso_oe_o,
    input  logic [DW-1:0] tx_byte_i,
    input  logic          cfg_enable_i,
    input  logic          cfg_cmp_en_i,
    input  logic          cfg_hiz_i,
    input  logic [DW-1:0] cmp_value_i,
    input  logic          rx_rd_i,
    input  logic          ovr_clr_i,
    output logic [DW-1:0] rx_data_o,
    output logic          rx_avail_o,
    output logic          rx_irq_o,
    output logic          ovr_o,
    output logic          match_o
);

    logic [2:0]    sync_q;
    logic          sck_s, ss_n_s, mosi_s;
    logic          sck_prev_q, act_prev_q;
    logic          act, start, rise, fall;
    logic          byte_done, deliver, oe, miso_bit, filt_muted;
    logic [DW-1:0] rx_byte;

    scs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_sck_i, spi_ss_n_i, spi_mosi_i}),
        .q_o   (sync_q)
    );

    assign {sck_s, ss_n_s, mosi_s} = sync_q;
    assign act   = cfg_enable_i && !ss_n_s;

    // Edge history of the synchronised serial clock and activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            act_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            act_prev_q <= act;
        end
    end

    assign start = act && !act_prev_q;
    assign rise  = sck_s && !sck_prev_q;
    assign fall  = !sck_s && sck_prev_q;

    scs_shifter #(.DW(DW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act),
        .start_i     (start),
        .rise_i      (rise),
        .fall_i      (fall),
        .mosi_i      (mosi_s),
        .tx_byte_i   (tx_byte_i),
        .byte_done_o (byte_done),
        .rx_byte_o   (rx_byte),
        .miso_bit_o  (miso_bit)
    );

    scs_filter #(.DW(DW)) u_filt (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act),
        .start_i     (start),
        .byte_done_i (byte_done),
        .rx_byte_i   (rx_byte),
        .cmp_en_i    (cfg_cmp_en_i),
        .cmp_value_i (cmp_value_i),
        .hiz_i       (cfg_hiz_i),
        .deliver_o   (deliver),
        .match_o     (match_o),
        .oe_o        (oe),
        .muted_o     (filt_muted)
    );

    scs_rxbuf #(.DW(DW)) u_rxbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .deliver_i (deliver),
        .byte_i    (rx_byte),
        .rd_i      (rx_rd_i),
        .ovr_clr_i (ovr_clr_i),
        .data_o    (rx_data_o),
        .avail_o   (rx_avail_o),
        .irq_o     (rx_irq_o),
        .ovr_o     (ovr_o)
    );

    assign spi_miso_oe_o = act && oe;
    assign spi_miso_o    = spi_miso_oe_o && miso_bit;

endmodule

// File: rtl/scs_checker.sv
// Property checker for spi_cmp_slave, attached by bind.
// Assumes a synchronous active-low reset on rst_n.
module scs_checker (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic avail,
    input logic ovr,
    input logic ovr_clr,
    input logic match,
    input logic oe,
    input logic muted
);

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                   // R1
    AST_IRQ_WITH_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> avail);                                  // R1
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);                      // R3
    AST_CMP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> !irq);                                 // R5
    AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);                               // R6
    AST_MUTE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        muted |-> !oe);                                  // R7

endmodule

bind spi_cmp_slave scs_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (rx_irq_o),
    .avail   (rx_avail_o),
    .ovr     (ovr_o),
    .ovr_clr (ovr_clr_i),
    .match   (match_o),
    .oe      (spi_miso_oe_o),
    .muted   (filt_muted)
);

// File: tb/tb_spi_cmp_slave.sv
// Self-checking bench: random transfers mixed with directed corner cases.
module tb_spi_cmp_slave;

    localparam int DW = 8;
    localparam int H  = 6;   // system clocks per serial half period

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic          miso, miso_oe;
    logic [DW-1:0] tx_byte = '0, cmp_value = '0;
    logic          en = 1'b0, cmp_en = 1'b0, hiz = 1'b0, rd = 1'b0, oclr = 1'b0;
    logic [DW-1:0] rx_data;
    logic          avail, irq, ovr, match;

    int errors = 0, checks = 0;
    int irq_cnt = 0, match_cnt = 0;
    bit done = 0;

    // Bench model of the buffer and filter.
    int            m_state;   // 0 idle, 1 compare, 2 pass, 3 mute
    logic [DW-1:0] m_data;
    logic          m_avail, m_ovr;
    int            m_irq, m_match;

    always #2 clk = ~clk;   // 250 MHz

    spi_cmp_slave #(.DW(DW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_ss_n_i(ss_n),
        .spi_mosi_i(mosi), .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
        .tx_byte_i(tx_byte), .cfg_enable_i(en), .cfg_cmp_en_i(cmp_en),
        .cfg_hiz_i(hiz), .cmp_value_i(cmp_value), .rx_rd_i(rd),
        .ovr_clr_i(oclr), .rx_data_o(rx_data), .rx_avail_o(avail),
        .rx_irq_o(irq), .ovr_o(ovr), .match_o(match)
    );

    // Count output pulses.
    always @(posedge clk) begin
        if (rst_n && irq)   irq_cnt++;
        if (rst_n && match) match_cnt++;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic f_oe(input int st, input logic h);
        return (st == 2) && !h;
    endfunction

    function automatic int f_next_state(input int st, input logic [DW-1:0] b, input logic [DW-1:0] c);
        if (st == 1) return (b == c) ? 2 : 3;
        return st;
    endfunction

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_txn(input logic [DW-1:0] tx0);
        tx_byte = tx0;
        ss_n = 1'b0;
        m_state = !en ? 0 : (cmp_en ? 1 : 2);
        clks(H);
    endtask

    task automatic end_txn();
        ss_n = 1'b1;
        m_state = 0;
        clks(2 * H);
    endtask

    // One byte: checks OE and DO bits, then updates the model.
    task automatic xfer(input string req, input logic [DW-1:0] din, input logic [DW-1:0] exp_out,
                        input logic [DW-1:0] next_tx);
        logic [DW-1:0] got = '0;
        logic oe_bad = 1'b0;
        logic exp_oe = f_oe(m_state, hiz);
        for (int b = DW - 1; b >= 0; b--) begin
            mosi = din[b];
            clks(H);
            got[b] = miso;
            if (miso_oe !== exp_oe) oe_bad = 1'b1;
            sck = 1'b1;
            if (b == 0) tx_byte = next_tx;
            clks(H);
            sck = 1'b0;
        end
        clks(1);
        chk(req, "oe during byte", oe_bad, 0);
        if (exp_oe) chk("R2", "dout byte", got, exp_out);
        if (m_state == 2) begin
            if (m_avail) m_ovr = 1'b1;
            m_avail = 1'b1; m_data = din; m_irq++;
        end else if (m_state == 1 && din == cmp_value) m_match++;
        m_state = f_next_state(m_state, din, cmp_value);
        chk(req, "rx_data", rx_data, m_data);
        chk(req, "avail", avail, m_avail);
        chk("R3", "ovr", ovr, m_ovr);
        chk(req, "irq count", irq_cnt, m_irq);
        chk("R6", "match count", match_cnt, m_match);
    endtask

    task automatic do_read();
        rd = 1'b1; clks(1); rd = 1'b0; m_avail = 1'b0;
    endtask

    task automatic do_oclr();
        oclr = 1'b1; clks(1); oclr = 1'b0; m_ovr = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240);
        m_state = 0; m_data = '0; m_avail = 0; m_ovr = 0; m_irq = 0; m_match = 0;
        clks(4);
        // R11: reset state
        chk("R11", "reset oe", miso_oe, 0);
        chk("R11", "reset data", rx_data, 0);
        chk("R11", "reset flags", {avail, irq, ovr, match}, 0);
        rst_n = 1'b1;
        en = 1'b1;
        clks(4);

        // R1/R2: plain two-byte transfer
        begin_txn(8'hA5);
        xfer("R1", 8'h3C, 8'hA5, 8'h5A);
        do_read();
        chk("R4", "avail after read", avail, 0);
        chk("R4", "data kept after read", rx_data, 8'h3C);
        xfer("R2", 8'hC3, 8'h5A, 8'h00);
        end_txn();

        // R3: overrun without read, then clear
        begin_txn(8'h81);
        xfer("R3", 8'h11, 8'h81, 8'h7E);
        xfer("R3", 8'h22, 8'h7E, 8'h00);
        end_txn();
        do_oclr();
        chk("R3", "ovr cleared", ovr, 0);
        do_read();

        // R5/R6: compare match
        cmp_en = 1'b1; cmp_value = 8'h4D;
        begin_txn(8'hFF);
        xfer("R5", 8'h4D, 8'hFF, 8'h96);
        xfer("R6", 8'h17, 8'h96, 8'h00);
        end_txn();
        do_read();

        // R7: compare mismatch mutes
        begin_txn(8'hFF);
        xfer("R7", 8'h4C, 8'hFF, 8'hAA);
        xfer("R7", 8'h99, 8'hAA, 8'h00);
        end_txn();

        // R8: tristate hold, reception continues
        cmp_en = 1'b0; hiz = 1'b1;
        begin_txn(8'hF0);
        xfer("R8", 8'h6B, 8'hF0, 8'h00);
        end_txn();
        hiz = 1'b0;
        do_read();

        // R9: aborted partial byte, then aligned transfer
        begin_txn(8'h00);
        for (int b = 0; b < 3; b++) begin
            mosi = 1'b1; clks(H); sck = 1'b1; clks(H); sck = 1'b0;
        end
        end_txn();
        chk("R9", "no irq after abort", irq_cnt, m_irq);
        chk("R9", "avail after abort", avail, 0);
        begin_txn(8'h3E);
        xfer("R9", 8'h52, 8'h3E, 8'h00);
        end_txn();
        do_read();

        // R10: engine disabled
        en = 1'b0;
        begin_txn(8'h12);
        xfer("R10", 8'hE7, 8'h12, 8'h00);
        end_txn();
        chk("R10", "data unchanged while disabled", rx_data, 8'h52);
        en = 1'b1;

        // Random transfers
        for (int t = 0; t < 60; t++) begin
            int nb;
            logic [DW-1:0] cur_tx, nxt_tx, d;
            cmp_en = $urandom_range(0, 1);
            hiz    = ($urandom_range(0, 5) == 0);
            cmp_value = $urandom;
            nb = $urandom_range(1, 4);
            cur_tx = $urandom;
            begin_txn(cur_tx);
            for (int k = 0; k < nb; k++) begin
                d = $urandom;
                if (k == 0 && cmp_en && $urandom_range(0, 1)) d = cmp_value;
                nxt_tx = $urandom;
                xfer(cmp_en ? "R6" : "R1", d, cur_tx, nxt_tx);
                cur_tx = nxt_tx;
                if ($urandom_range(0, 2) != 0) do_read();
                if ($urandom_range(0, 3) == 0) do_oclr();
            end
            end_txn();
        end
        hiz = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule